// File: doc/BRIEF.md
# Cutset-pipelined three-tap FIR filter

The block is a single-rate finite impulse response filter with three taps. It computes y(n) = a·x(n) + b·x(n-1) + c·x(n-2) on signed samples, taking at most one new sample per clock. An input strobe marks each sample. The three coefficients sit in registers that are written together by a single strobe.

Two registers sit on a feed-forward cutset. The first holds the partial sum a·x(n) + b·x(n-1). The second, alongside it, holds the product c·x(n-2). A final adder joins the two and feeds a registered output. The longest register-to-register path is therefore one multiply and one add, where the plain form has one multiply and two adds. Each path from input to output gains exactly one register, and two consecutive results are always in flight.

The result is kept at full precision: DATA_W + COEF_W + 2 bits, which is 34 bits with the default widths. Nothing is rounded or saturated. Coefficients are meant to be written while the stream is idle.

Top module: `cutset_fir3`

## Requirements
- R1: While rst_n is low and after its release, out_valid is 0, out_y is 0, all coefficients are 0 and both stored past samples are 0.
- R2: Every produced result equals a·x(n) + b·x(n-1) + c·x(n-2) exactly, as a two's complement value of DATA_W+COEF_W+2 bits. Here x(n) is the newest accepted sample, x(n-1) and x(n-2) are the two accepted before it, and a, b and c are coef_a, coef_b and coef_c.
- R3: A sample accepted at clock edge k (in_valid high) makes out_valid high, with its result on out_y, after edge k+2. That is one edge more than a filter with only an output register.
- R4: A cycle with in_valid low is ignored. The sample does not enter the history, no result is produced, out_valid is low two edges later, and out_y keeps its last value.
- R5: The first two results after reset treat the samples before the first accepted one as zero.
- R6: When coef_wr is high at an edge, all three coefficients load from coef_a, coef_b and coef_c. A sample accepted at that same edge still uses the old coefficients; later samples use the new ones. While coef_wr is low, the coefficients hold.
- R7: With in_valid held high, one result leaves per clock with no gaps. Two results are in progress in every cycle.
- R8: Most-negative and most-positive operands, including all three products at -2^15·-2^15, give the exact full-precision sum with no wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| coef_wr | input | 1 | Loads all three coefficients at this edge |
| coef_a | input | COEF_W | Coefficient for the newest sample |
| coef_b | input | COEF_W | Coefficient for the sample one step old |
| coef_c | input | COEF_W | Coefficient for the sample two steps old |
| in_valid | input | 1 | Marks in_x as a sample to accept |
| in_x | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Marks out_y as a new result |
| out_y | output | DATA_W+COEF_W+2 | Signed full-precision result |

## Verification
A unit impulse shows that each coefficient reaches its own tap, in the right order and with the right delay. A dense sweep of small signed samples under several coefficient sets, sent back to back, shows correct sign handling and the one-per-clock rate. Streams with gaps show that idle cycles neither shift the history nor disturb the held output. Extreme operands, a coefficient write on the same edge as a sample, and a long random stream with random gaps separate exact full-precision arithmetic, the old-versus-new coefficient boundary and the two-edge latency from near misses.

// File: rtl/fir3_pkg.sv
package fir3_pkg;
  localparam int NUM_TAPS = 3;

  // width of a single product
  function automatic int prod_width(input int dw, input int cw);
    return dw + cw;
  endfunction

  // growth of two bits covers the sum of three products
  function automatic int sum_width(input int dw, input int cw);
    return dw + cw + $clog2(NUM_TAPS + 1);
  endfunction
endpackage

// File: rtl/fir3_coef_bank.sv
module fir3_coef_bank #(
  parameter int COEF_W = 16,
  parameter int NTAP   = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [NTAP-1:0][COEF_W-1:0]     wr_data,
  output logic [NTAP-1:0][COEF_W-1:0]     coef_q
);
  logic [NTAP-1:0][COEF_W-1:0] coef_d;

  generate
    for (genvar t = 0; t < NTAP; t++) begin : g_tap
      always_comb begin
        coef_d[t] = coef_q[t];
        if (wr_en) coef_d[t] = wr_data[t];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) coef_q[t] <= '0;
        else        coef_q[t] <= coef_d[t];
      end
    end
  endgenerate

  // R6: without a write strobe the coefficients hold
  p_coef_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(coef_q));
endmodule

// File: rtl/fir3_delay_line.sv
module fir3_delay_line #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         shift_en,
  input  logic [DATA_W-1:0]            din,
  output logic [DEPTH-1:0][DATA_W-1:0] tap_q
);
  logic [DEPTH-1:0][DATA_W-1:0] tap_d;

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      logic [DATA_W-1:0] src;
      if (s == 0) begin : g_head
        assign src = din;
      end else begin : g_body
        assign src = tap_q[s-1];
      end

      always_comb begin
        tap_d[s] = tap_q[s];
        if (shift_en) tap_d[s] = src;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap_q[s] <= '0;
        else        tap_q[s] <= tap_d[s];
      end
    end
  endgenerate

  // R4: an idle cycle leaves the history untouched
  p_hist_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(tap_q));
  // R7: an accepted sample moves into the first history slot
  p_hist_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> tap_q[0] == $past(din));
endmodule

// File: rtl/fir3_cut_stage.sv
module fir3_cut_stage #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  localparam int PR_W  = fir3_pkg::prod_width(DATA_W, COEF_W),
  localparam int PS_W  = PR_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] x_now,
  input  logic signed [DATA_W-1:0] x_old1,
  input  logic signed [DATA_W-1:0] x_old2,
  input  logic signed [COEF_W-1:0] k_now,
  input  logic signed [COEF_W-1:0] k_old1,
  input  logic signed [COEF_W-1:0] k_old2,
  output logic                     cut_valid,
  output logic signed [PS_W-1:0]   psum_q,
  output logic signed [PR_W-1:0]   cterm_q
);
  logic signed [PR_W-1:0] prod_now, prod_old1, prod_old2;
  logic signed [PS_W-1:0] psum_d;
  logic signed [PR_W-1:0] cterm_d;

  // one multiply plus one add ahead of the cutset registers
  always_comb begin
    prod_now  = x_now  * k_now;
    prod_old1 = x_old1 * k_old1;
    prod_old2 = x_old2 * k_old2;
    psum_d    = psum_q;
    cterm_d   = cterm_q;
    if (in_valid) begin
      psum_d  = {prod_now[PR_W-1], prod_now} + {prod_old1[PR_W-1], prod_old1};
      cterm_d = prod_old2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cut_valid <= 1'b0;
      psum_q    <= '0;
      cterm_q   <= '0;
    end else begin
      cut_valid <= in_valid;
      psum_q    <= psum_d;
      cterm_q   <= cterm_d;
    end
  end

  // R4: the cutset registers hold across an idle cycle
  p_cut_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(psum_q) && $stable(cterm_q));
endmodule

// File: rtl/fir3_join.sv
module fir3_join #(
  parameter int PS_W  = 33,
  parameter int PR_W  = 32,
  parameter int OUT_W = 34
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cut_valid,
  input  logic signed [PS_W-1:0]  psum_q,
  input  logic signed [PR_W-1:0]  cterm_q,
  output logic                    y_valid,
  output logic signed [OUT_W-1:0] y_q
);
  logic signed [OUT_W-1:0] y_d;

  always_comb begin
    y_d = y_q;
    if (cut_valid)
      y_d = {{(OUT_W-PS_W){psum_q[PS_W-1]}}, psum_q} +
            {{(OUT_W-PR_W){cterm_q[PR_W-1]}}, cterm_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_valid <= 1'b0;
      y_q     <= '0;
    end else begin
      y_valid <= cut_valid;
      y_q     <= y_d;
    end
  end

  // R4: the output value holds when the cutset carries nothing
  p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cut_valid |=> $stable(y_q));
endmodule

// File: rtl/cutset_fir3.sv
module cutset_fir3 #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  localparam int NTAP  = fir3_pkg::NUM_TAPS,
  localparam int PR_W  = fir3_pkg::prod_width(DATA_W, COEF_W),
  localparam int PS_W  = PR_W + 1,
  localparam int OUT_W = fir3_pkg::sum_width(DATA_W, COEF_W)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     coef_wr,
  input  logic signed [COEF_W-1:0] coef_a,
  input  logic signed [COEF_W-1:0] coef_b,
  input  logic signed [COEF_W-1:0] coef_c,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_x,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_y
);
  logic [NTAP-1:0][COEF_W-1:0]   coef_in, coef_q;
  logic [NTAP-2:0][DATA_W-1:0]   hist_q;
  logic                          cut_valid;
  logic signed [PS_W-1:0]        psum_q;
  logic signed [PR_W-1:0]        cterm_q;

  assign coef_in = {coef_c, coef_b, coef_a};

  fir3_coef_bank #(.COEF_W(COEF_W), .NTAP(NTAP)) u_coef (
    .clk(clk), .rst_n(rst_n), .wr_en(coef_wr),
    .wr_data(coef_in), .coef_q(coef_q)
  );

  fir3_delay_line #(.DATA_W(DATA_W), .DEPTH(NTAP-1)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(in_valid),
    .din(in_x), .tap_q(hist_q)
  );

  fir3_cut_stage #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_cut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .x_now(in_x),
    .x_old1(hist_q[0]), .x_old2(hist_q[1]),
    .k_now(coef_q[0]), .k_old1(coef_q[1]), .k_old2(coef_q[2]),
    .cut_valid(cut_valid), .psum_q(psum_q), .cterm_q(cterm_q)
  );

  fir3_join #(.PS_W(PS_W), .PR_W(PR_W), .OUT_W(OUT_W)) u_join (
    .clk(clk), .rst_n(rst_n), .cut_valid(cut_valid),
    .psum_q(psum_q), .cterm_q(cterm_q),
    .y_valid(out_valid), .y_q(out_y)
  );

  // R3: an accepted sample yields a result exactly two edges later
  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
  // R4: an idle cycle yields no result two edges later
  p_idle_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);
endmodule

// File: tb/tb_cutset_fir3.sv
`timescale 1ns/1ps
module tb_cutset_fir3;
  logic clk = 1'b0;
  logic rst_n;
  logic coef_wr;
  logic signed [15:0] coef_a, coef_b, coef_c;
  logic in_valid;
  logic signed [15:0] in_x;
  logic out_valid;
  logic signed [33:0] out_y;

  always #2 clk = ~clk;

  cutset_fir3 dut (
    .clk(clk), .rst_n(rst_n), .coef_wr(coef_wr),
    .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c),
    .in_valid(in_valid), .in_x(in_x),
    .out_valid(out_valid), .out_y(out_y)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string cur_req = "R2";

  // bench model
  longint ma = 0, mb = 0, mc = 0, h1 = 0, h2 = 0;
  bit e1_v = 0, e2_v = 0;
  longint e1_y = 0, e2_y = 0, last_y = 0;
  bit wr_pend = 0;
  longint na = 0, nb = 0, nc = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input int x);
    longint y;
    @(negedge clk);
    check(out_valid == e2_v, "R3", longint'(out_valid), longint'(e2_v));
    if (e2_v) begin
      check(longint'(out_y) == e2_y, cur_req, longint'(out_y), e2_y);
      last_y = e2_y;
    end else begin
      check(longint'(out_y) == last_y, "R4", longint'(out_y), last_y);
    end
    in_valid = v;
    in_x     = 16'(x);
    coef_wr  = wr_pend;
    coef_a   = 16'(na);
    coef_b   = 16'(nb);
    coef_c   = 16'(nc);
    y = 0;
    if (v) begin
      y  = ma * longint'($signed(16'(x))) + mb * h1 + mc * h2;
      h2 = h1;
      h1 = longint'($signed(16'(x)));
    end
    if (wr_pend) begin
      ma = na; mb = nb; mc = nc;
      wr_pend = 0;
    end
    e2_v = e1_v; e2_y = e1_y;
    e1_v = v;    e1_y = y;
  endtask

  task automatic set_coef(input int a, input int b, input int c);
    wr_pend = 1; na = a; nb = b; nc = c;
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) step(0, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; coef_wr = 0; coef_a = 0; coef_b = 0; coef_c = 0;
    in_valid = 0; in_x = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports
    check(out_valid == 1'b0, "R1", longint'(out_valid), 0);
    check(out_y == '0, "R1", longint'(out_y), 0);
    rst_n = 1;

    // R1: coefficients reset to zero, so a sample gives 0
    cur_req = "R1";
    step(1, 1234);
    flush();

    // R5: first results after reset, zero history (restart from reset)
    rst_n = 0; h1 = 0; h2 = 0; ma = 0; mb = 0; mc = 0;
    e1_v = 0; e2_v = 0; last_y = 0;
    @(negedge clk); rst_n = 1;
    cur_req = "R5";
    set_coef(3, -5, 7);
    step(0, 0);
    step(1, 100);
    step(1, -20);
    step(1, 9);
    flush();

    // R2: impulse exposes tap order a, b, c
    cur_req = "R2";
    set_coef(11, -22, 33);
    step(0, 0);
    step(1, 0); step(1, 0);
    step(1, 1); step(1, 0); step(1, 0); step(1, 0);
    flush();

    // R7 / R2: dense sweep of small samples, back to back
    cur_req = "R7";
    for (int cs = 0; cs < 4; cs++) begin
      set_coef(cs * 5 - 7, 13 - cs * 9, cs * cs - 3);
      step(0, 0);
      for (int x = -8; x < 8; x++)
        for (int z = -8; z < 8; z++) begin
          step(1, x); step(1, z);
        end
    end
    flush();

    // R4: gaps between samples
    cur_req = "R4";
    set_coef(-4, 6, 2);
    step(0, 0);
    for (int i = 0; i < 40; i++) begin
      step(1, i * 37 - 700);
      for (int g = 0; g < (i % 3); g++) step(0, 31000 - i);
    end
    flush();

    // R6: write lands on the same edge as a sample
    cur_req = "R6";
    step(1, 500); step(1, -300);
    set_coef(9, 8, -7);
    step(1, 250);
    step(1, 40); step(1, -60); step(1, 5);
    flush();

    // R8: extreme operands
    cur_req = "R8";
    set_coef(-32768, -32768, -32768);
    step(0, 0);
    for (int i = 0; i < 4; i++) step(1, -32768);
    step(1, 32767); step(1, -32768); step(1, 32767);
    set_coef(32767, -32768, 32767);
    step(0, 0);
    step(1, -32768); step(1, 32767); step(1, -32768); step(1, -32768);
    flush();

    // R2: long random stream with random gaps and idle coefficient updates
    cur_req = "R2";
    for (int blk = 0; blk < 20; blk++) begin
      flush();
      set_coef($urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768,
               $urandom_range(0, 65535) - 32768);
      step(0, 0);
      for (int i = 0; i < 200; i++)
        step($urandom_range(0, 3) != 0, $urandom_range(0, 65535) - 32768);
    end
    flush();

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule